// File: doc/BRIEF.md
# Transfer Parameter Link and Chain Controller

This block holds a table of DMA transfer descriptors (parameter sets) and decides when each channel may start. Channel `c` always runs from set `c`, its active set. A channel is started by a manual pulse from the processor, by a peripheral event (regular channels only), by a chain trigger raised when another channel finishes, or, for the quick channels, by a write to the one field of its active set that the set itself names as its trigger word. Each start is reported as a one-cycle pulse carrying the channel number. Moving the data is left to an external sequencer, which reports intermediate and final completions back.

When a channel reports final completion, the controller copies the whole set named by the active set's link field into the active set, one field per cycle. A link value of all ones installs a null set instead. A completion can also raise a trigger on another channel. Two channels that chain to each other, each linked to a saved image of its own set, therefore alternate with no processor help after one manual start.

Top module: `dma_linkchain_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, `start_valid` is 0. Triggers presented during reset are not remembered.
- R2: A manual pulse on `man_trig[c]`, or an event pulse on `evt_trig[c]` for a regular channel, makes `start_valid`=1 with `start_ch`=c on the cycle after the capturing edge, provided set c has a nonzero count field.
- R3: Field codes are OPT=0, SRC=1, DST=2, CNT=3, LINK=4. Quick channels are the top NQ channel numbers (6 and 7 by default). The trigger-word field code is OPT bits [14:12] as already stored. A host write to that field of a quick channel's active set starts the channel. A write to any other field of that set does not.
- R4: A completion with `cmp_final`=0 raises a chain trigger only if OPT bit 0 of the finishing channel's set is 1. A completion with `cmp_final`=1 raises one only if OPT bit 1 is 1. The target channel is OPT bits [4 +: log2(NCH)].
- R5: A final completion replaces every field of the active set with the matching field of the set whose index is the low bits of the LINK field. The copy takes one field per cycle for five cycles. The new OPT then governs later completions.
- R6: When LINK is 0xFFFF, a final completion installs a null set: all fields zero and LINK 0xFFFF. A trigger on a set whose count field is zero is dropped and produces no start.
- R7: A trigger for a channel whose reload is in progress is held. It starts on the cycle after the reload's last copy, not before.
- R8: At most one channel starts per cycle. Among pending eligible channels the lowest number starts first, and the others stay pending.
- R9: Two channels that chain to each other on final completion, each linked to a copy of its own set, alternate starts over repeated completions after one manual start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe for a parameter field |
| wr_set | input | log2(NSETS) | Set index of the write |
| wr_fld | input | 3 | Field code of the write |
| wr_data | input | 16 | Field value |
| man_trig | input | NCH | Manual start pulses, one per channel |
| evt_trig | input | NCH-NQ | Peripheral event pulses for the regular channels |
| cmp_valid | input | 1 | Completion report from the sequencer |
| cmp_ch | input | log2(NCH) | Channel that completed |
| cmp_final | input | 1 | 1 = final completion, 0 = intermediate |
| start_valid | output | 1 | Start pulse |
| start_ch | output | log2(NCH) | Channel being started |

## Verification
The checks assume that completions arrive only for channels that were started, and that a new completion never arrives while a reload is still copying. They also assume that the host does not write a set while that set is being reloaded, and that chain targets name existing channels. The stimulus follows every final completion with at least eight idle cycles and writes parameters only while no reload is in progress. Every scenario is driven from that quiet state, so each start can be attributed to exactly one trigger.

// File: rtl/dmalc_pkg.sv
package dmalc_pkg;

    localparam int FW = 16;
    localparam int NF = 5;

    typedef enum logic [2:0] {
        FLD_OPT  = 3'd0,
        FLD_SRC  = 3'd1,
        FLD_DST  = 3'd2,
        FLD_CNT  = 3'd3,
        FLD_LINK = 3'd4
    } fld_e;

    localparam logic [FW-1:0] LINK_NONE = 16'hFFFF;

    localparam int OPT_CHAIN_MID = 0;
    localparam int OPT_CHAIN_END = 1;
    localparam int OPT_TGT_LSB   = 4;
    localparam int OPT_QSEL_LSB  = 12;

    typedef struct packed {
        logic       busy;
        logic       nul;
        logic [2:0] idx;
    } rl_state_t;

    function automatic logic [FW-1:0] null_word(input logic [2:0] f);
        return (f == FLD_LINK) ? LINK_NONE : '0;
    endfunction

endpackage

// File: rtl/dmalc_ptable.sv
module dmalc_ptable
    import dmalc_pkg::*;
#(
    parameter int NSETS = 128,
    parameter int NCH   = 8,
    localparam int SW = $clog2(NSETS),
    localparam int CW = $clog2(NCH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_we,
    input  logic [SW-1:0] host_set,
    input  logic [2:0]    host_fld,
    input  logic [FW-1:0] host_data,
    input  logic          rl_we,
    input  logic [SW-1:0] rl_set,
    input  logic [2:0]    rl_fld,
    input  logic [FW-1:0] rl_data,
    input  logic [SW-1:0] rd_set,
    input  logic [2:0]    rd_fld,
    output logic [FW-1:0] rd_data,
    output logic [NCH-1:0] ch_mid,
    output logic [NCH-1:0] ch_end,
    output logic [CW-1:0]  ch_tgt [NCH],
    output logic [FW-1:0]  ch_link [NCH],
    output logic [NCH-1:0] ch_cnt_nz,
    output logic [NCH-1:0] ch_qhit
);

    logic [FW-1:0] mem [NSETS][NF];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NSETS; s++)
                for (int f = 0; f < NF; f++)
                    mem[s][f] <= '0;
        end else begin
            if (host_we && (host_fld < 3'(NF)))
                mem[host_set][host_fld] <= host_data;
            if (rl_we)
                mem[rl_set][rl_fld] <= rl_data;
        end
    end

    assign rd_data = mem[rd_set][rd_fld];

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [FW-1:0] opt;
        assign opt          = mem[c][FLD_OPT];
        assign ch_mid[c]    = opt[OPT_CHAIN_MID];
        assign ch_end[c]    = opt[OPT_CHAIN_END];
        assign ch_tgt[c]    = opt[OPT_TGT_LSB +: CW];
        assign ch_link[c]   = mem[c][FLD_LINK];
        assign ch_cnt_nz[c] = (mem[c][FLD_CNT] != '0);
        assign ch_qhit[c]   = host_we && (host_set == SW'(c))
                              && (host_fld == opt[OPT_QSEL_LSB +: 3]);
    end

endmodule

// File: rtl/dmalc_reload.sv
module dmalc_reload
    import dmalc_pkg::*;
#(
    parameter int NSETS = 128,
    parameter int NCH   = 8,
    localparam int SW = $clog2(NSETS),
    localparam int CW = $clog2(NCH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic [CW-1:0] go_ch,
    input  logic [FW-1:0] go_link,
    output logic          busy,
    output logic [CW-1:0] cur_ch,
    output logic [SW-1:0] src_set,
    output logic [2:0]    fld,
    input  logic [FW-1:0] src_data,
    output logic          wr_en,
    output logic [SW-1:0] wr_set,
    output logic [FW-1:0] wr_data
);

    rl_state_t     st;
    logic [CW-1:0] ch_q;
    logic [SW-1:0] src_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= '0;
            ch_q  <= '0;
            src_q <= '0;
        end else if (!st.busy) begin
            if (go) begin
                st.busy <= 1'b1;
                st.nul  <= (go_link == LINK_NONE);
                st.idx  <= '0;
                ch_q    <= go_ch;
                src_q   <= go_link[SW-1:0];
            end
        end else begin
            st.idx <= st.idx + 3'd1;
            if (st.idx == 3'(NF - 1))
                st.busy <= 1'b0;
        end
    end

    assign busy    = st.busy;
    assign cur_ch  = ch_q;
    assign src_set = src_q;
    assign fld     = st.idx;
    assign wr_en   = st.busy;
    assign wr_set  = SW'(ch_q);
    assign wr_data = st.nul ? null_word(st.idx) : src_data;

    // R5: a reload ends only after the last field has been copied
    p_full_copy_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(st.busy) |-> ($past(st.idx) == 3'(NF - 1)));

    // R7: completions never overlap a reload in progress (input assumption)
    p_no_overlap_r7: assert property (@(posedge clk) disable iff (rst)
        go |-> !st.busy);

endmodule

// File: rtl/dmalc_arb.sv
module dmalc_arb #(
    parameter int NCH = 8,
    localparam int CW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] trig,
    input  logic [NCH-1:0] cnt_nz,
    input  logic [NCH-1:0] blocked,
    output logic           start_valid,
    output logic [CW-1:0]  start_ch
);

    logic [NCH-1:0] pend, elig, drop, grant;
    logic [CW-1:0]  pick;
    logic           any;

    assign elig = pend & cnt_nz & ~blocked;
    assign drop = pend & ~cnt_nz & ~blocked;

    always_comb begin
        pick = '0;
        any  = 1'b0;
        for (int c = NCH - 1; c >= 0; c--) begin
            if (elig[c]) begin
                pick = CW'(c);
                any  = 1'b1;
            end
        end
    end

    assign grant = any ? (NCH'(1) << pick) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend        <= '0;
            start_valid <= 1'b0;
            start_ch    <= '0;
        end else begin
            pend        <= (pend & ~drop & ~grant) | trig;
            start_valid <= any;
            start_ch    <= pick;
        end
    end

    // R8: the started channel was pending in the previous cycle
    p_start_pending_r8: assert property (@(posedge clk) disable iff (rst)
        start_valid |-> ((($past(pend) >> start_ch) & NCH'(1)) != '0));

    // R8: no lower-numbered channel was eligible when the grant was made
    p_lowest_first_r8: assert property (@(posedge clk) disable iff (rst)
        start_valid |-> (($past(elig) & ((NCH'(1) << start_ch) - NCH'(1))) == '0));

    // R6: a start never comes from a set whose count is zero
    p_nonzero_count_r6: assert property (@(posedge clk) disable iff (rst)
        start_valid |-> ((($past(cnt_nz) >> start_ch) & NCH'(1)) != '0));

endmodule

// File: rtl/dma_linkchain_ctrl.sv
module dma_linkchain_ctrl
    import dmalc_pkg::*;
#(
    parameter int NSETS = 128,
    parameter int NCH   = 8,
    parameter int NQ    = 2,
    localparam int SW   = $clog2(NSETS),
    localparam int CW   = $clog2(NCH),
    localparam int NREG = NCH - NQ
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [SW-1:0]   wr_set,
    input  logic [2:0]      wr_fld,
    input  logic [15:0]     wr_data,
    input  logic [NCH-1:0]  man_trig,
    input  logic [NREG-1:0] evt_trig,
    input  logic            cmp_valid,
    input  logic [CW-1:0]   cmp_ch,
    input  logic            cmp_final,
    output logic            start_valid,
    output logic [CW-1:0]   start_ch
);

    localparam logic [NCH-1:0] QMASK = {{NQ{1'b1}}, {NREG{1'b0}}};

    logic [NCH-1:0] ch_mid, ch_end, ch_cnt_nz, ch_qhit;
    logic [CW-1:0]  ch_tgt [NCH];
    logic [FW-1:0]  ch_link [NCH];

    logic          rl_busy, rl_we;
    logic [CW-1:0] rl_ch;
    logic [SW-1:0] rl_src, rl_set;
    logic [2:0]    rl_fld;
    logic [FW-1:0] rl_rdata, rl_wdata;

    logic           chain_fire;
    logic [NCH-1:0] chain_vec, trig, blocked;

    dmalc_ptable #(.NSETS(NSETS), .NCH(NCH)) u_tab (
        .clk(clk), .rst(rst),
        .host_we(wr_en), .host_set(wr_set), .host_fld(wr_fld), .host_data(wr_data),
        .rl_we(rl_we), .rl_set(rl_set), .rl_fld(rl_fld), .rl_data(rl_wdata),
        .rd_set(rl_src), .rd_fld(rl_fld), .rd_data(rl_rdata),
        .ch_mid(ch_mid), .ch_end(ch_end), .ch_tgt(ch_tgt), .ch_link(ch_link),
        .ch_cnt_nz(ch_cnt_nz), .ch_qhit(ch_qhit)
    );

    dmalc_reload #(.NSETS(NSETS), .NCH(NCH)) u_rl (
        .clk(clk), .rst(rst),
        .go(cmp_valid && cmp_final), .go_ch(cmp_ch), .go_link(ch_link[cmp_ch]),
        .busy(rl_busy), .cur_ch(rl_ch), .src_set(rl_src), .fld(rl_fld),
        .src_data(rl_rdata), .wr_en(rl_we), .wr_set(rl_set), .wr_data(rl_wdata)
    );

    assign chain_fire = cmp_valid && (cmp_final ? ch_end[cmp_ch] : ch_mid[cmp_ch]);
    assign chain_vec  = chain_fire ? (NCH'(1) << ch_tgt[cmp_ch]) : '0;
    assign trig       = man_trig | {{NQ{1'b0}}, evt_trig} | chain_vec | (ch_qhit & QMASK);
    assign blocked    = rl_busy ? (NCH'(1) << rl_ch) : '0;

    dmalc_arb #(.NCH(NCH)) u_arb (
        .clk(clk), .rst(rst),
        .trig(trig), .cnt_nz(ch_cnt_nz), .blocked(blocked),
        .start_valid(start_valid), .start_ch(start_ch)
    );

    // R7: no start for the channel that was reloading in the deciding cycle
    p_hold_in_reload_r7: assert property (@(posedge clk) disable iff (rst)
        (start_valid && $past(rl_busy)) |-> (start_ch != $past(rl_ch)));

    // R1: the cycle right after reset carries no start
    p_quiet_after_reset_r1: assert property (@(posedge clk)
        $past(rst) |-> !start_valid);

endmodule

// File: tb/tb_dma_linkchain_ctrl.sv
module tb_dma_linkchain_ctrl;

    localparam int NSETS = 128;
    localparam int NCH   = 8;
    localparam int NQ    = 2;
    localparam int SW    = $clog2(NSETS);
    localparam int CW    = $clog2(NCH);
    localparam int NREG  = NCH - NQ;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            wr_en = 1'b0;
    logic [SW-1:0]   wr_set = '0;
    logic [2:0]      wr_fld = '0;
    logic [15:0]     wr_data = '0;
    logic [NCH-1:0]  man_trig = '0;
    logic [NREG-1:0] evt_trig = '0;
    logic            cmp_valid = 1'b0;
    logic [CW-1:0]   cmp_ch = '0;
    logic            cmp_final = 1'b0;
    logic            start_valid;
    logic [CW-1:0]   start_ch;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    dma_linkchain_ctrl #(.NSETS(NSETS), .NCH(NCH), .NQ(NQ)) dut (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_set(wr_set), .wr_fld(wr_fld), .wr_data(wr_data),
        .man_trig(man_trig), .evt_trig(evt_trig),
        .cmp_valid(cmp_valid), .cmp_ch(cmp_ch), .cmp_final(cmp_final),
        .start_valid(start_valid), .start_ch(start_ch)
    );

    // setup vectors: {set[31:24], field[23:16], value[15:0]}
    localparam int NSETUP = 28;
    localparam logic [31:0] SETUP [NSETUP] = '{
        32'h00_00_0012, 32'h00_03_0004, 32'h00_04_0040,
        32'h40_00_0012, 32'h40_03_0004, 32'h40_04_0040,
        32'h01_00_0002, 32'h01_03_0004, 32'h01_04_0041,
        32'h41_00_0002, 32'h41_03_0004, 32'h41_04_0041,
        32'h02_03_0001, 32'h02_04_FFFF,
        32'h03_00_0051, 32'h03_03_0001, 32'h03_04_FFFF,
        32'h04_00_0042, 32'h04_03_0001, 32'h04_04_0042,
        32'h42_03_0001,
        32'h05_03_0001,
        32'h06_00_2000, 32'h06_03_0001,
        32'h07_00_1000, 32'h07_03_0001,
        32'h05_01_00AA, 32'h05_02_00BB
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int s, input int f, input int d);
        wr_en = 1'b1; wr_set = SW'(s); wr_fld = 3'(f); wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic man(input logic [NCH-1:0] m);
        man_trig = m;
        @(negedge clk);
        man_trig = '0;
    endtask

    task automatic ev(input int c);
        evt_trig = NREG'(1) << c;
        @(negedge clk);
        evt_trig = '0;
    endtask

    task automatic cmp(input int c, input bit fin);
        cmp_valid = 1'b1; cmp_ch = CW'(c); cmp_final = fin;
        @(negedge clk);
        cmp_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_start(input int ch, input string req);
        int seen = -1;
        for (int i = 0; i < 12 && seen < 0; i++) begin
            @(negedge clk);
            if (start_valid) seen = int'(start_ch);
        end
        chk(seen == ch, req, seen, ch);
    endtask

    task automatic expect_quiet(input int n, input string req);
        int seen = -1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (start_valid && seen < 0) seen = int'(start_ch);
        end
        chk(seen < 0, req, seen, -1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset quiet, triggers during reset forgotten
        @(negedge clk);
        man_trig = '1;
        idle(3);
        chk(start_valid == 1'b0, "R1 during reset", int'(start_valid), 0);
        man_trig = '0;
        rst = 1'b0;
        expect_quiet(4, "R1 after reset");

        for (int i = 0; i < NSETUP; i++)
            wr(int'(SETUP[i][31:24]), int'(SETUP[i][23:16]), int'(SETUP[i][15:0]));
        expect_quiet(3, "R6 zero-count quick write dropped");

        // R3: quick channel trigger word
        wr(6, 1, 16'h1234);
        expect_quiet(4, "R3 non-trigger field");
        wr(6, 2, 16'h5678);
        expect_start(6, "R3 trigger word DST");
        wr(7, 1, 16'h0009);
        expect_start(7, "R3 trigger word SRC");

        // R2 event, R4 intermediate and final chain enables
        ev(3);
        expect_start(3, "R2 event start");
        cmp(3, 1'b0);
        expect_start(5, "R4 intermediate chain");
        cmp(3, 1'b1);
        expect_quiet(8, "R4 final chain disabled");
        ev(3);
        expect_quiet(4, "R6 null set after final");

        // R2 manual, R6 null link
        man(8'h04);
        expect_start(2, "R2 manual start");
        cmp(2, 1'b1);
        idle(8);
        man(8'h04);
        expect_quiet(4, "R6 null link no transfer");

        // R8 priority
        man(8'h30);
        @(negedge clk);
        chk(start_valid && start_ch == 3'd4, "R8 lowest first", int'(start_ch), 4);
        @(negedge clk);
        chk(start_valid && start_ch == 3'd5, "R8 second pending", int'(start_ch), 5);

        // R7 hold during reload, R5 copied OPT in effect
        cmp(4, 1'b1);
        expect_quiet(5, "R7 held during reload");
        @(negedge clk);
        chk(start_valid && start_ch == 3'd4, "R7 start after reload", int'(start_ch), 4);
        idle(4);
        cmp(4, 1'b1);
        expect_quiet(8, "R5 reloaded OPT has no chain");

        // R9 ping-pong
        idle(4);
        man(8'h01);
        expect_start(0, "R9 first manual start");
        for (int r = 0; r < 3; r++) begin
            cmp(0, 1'b1);
            expect_start(1, "R9 ping to pong");
            idle(8);
            cmp(1, 1'b1);
            expect_start(0, "R9 pong to ping");
            idle(8);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule